// File: doc/BRIEF.md
# Dual-Trigger Sawtooth Ramp Generator

This block produces a 12-bit code for a digital-to-analog converter that follows a sawtooth ramp. Two separate single-cycle pulses drive it. One restarts the ramp from a programmed start level. The other moves the ramp by a programmed step, either upward or downward.

A 16-bit accumulator holds the ramp. It has 12 integer bits and 4 fractional bits, so a step smaller than one output code builds up over several pulses. The ramp clamps at both ends and never wraps. The integer part of the accumulator reaches the output through a pipeline, so the new code appears a fixed three clock cycles after the pulse that caused it. Selecting and multiplexing the pulse sources is done outside the block.

Top module: `saw_ramp_gen`

## Requirements
- R1: While `rst_n` is low, the accumulator and `dac_code` are cleared to zero.
- R2: A `restart_trig` pulse loads the accumulator with `restart_val` in bits 15:4 and zero in fraction bits 3:0.
- R3: When `restart_trig` and `step_trig` are high in the same cycle, only the restart takes effect.
- R4: A `step_trig` pulse with `ramp_down` = 0 adds `step_val` to the accumulator. `step_val` bits 3:0 are fraction, so fractional steps carry into the integer part.
- R5: A `step_trig` pulse with `ramp_down` = 1 subtracts `step_val` from the accumulator.
- R6: A rising step that would pass 16'hFFFF leaves the accumulator at 16'hFFFF, so `dac_code` is 12'hFFF.
- R7: A falling step that would go below zero leaves the accumulator at zero.
- R8: With neither trigger high, the accumulator and `dac_code` hold their value, even if `restart_val`, `step_val` or `ramp_down` change.
- R9: `dac_code` shows accumulator bits 15:4 after the third rising clock edge that follows the edge sampling the trigger. It does not change before then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| restart_val | input | 12 | Integer start level loaded on a restart |
| step_val | input | 16 | Step amount, 12 integer bits and 4 fraction bits |
| ramp_down | input | 1 | 0 for a rising ramp, 1 for a falling ramp |
| restart_trig | input | 1 | One-cycle pulse that restarts the ramp |
| step_trig | input | 1 | One-cycle pulse that moves the ramp by one step |
| dac_code | output | 12 | Ramp code for the converter, delayed by three cycles |

## Verification
The assertions assume the configuration inputs (`restart_val`, `step_val`, `ramp_down`) are steady in any cycle where a trigger is high, and that triggers are single-cycle pulses sampled on the rising edge. The stimulus meets this by setting the configuration and the pulse together on a falling edge and dropping the pulse on the next falling edge. It then leaves enough quiet cycles for each result to pass through the pipeline before the next pulse. Configuration changes with no trigger are made only in a dedicated hold test, where the assertions expect the accumulator to stay unchanged.

// File: rtl/saw_ramp_gen.sv
module saw_ramp_gen #(
  parameter int OUT_W   = 12,
  parameter int FRAC_W  = 4,
  parameter int LATENCY = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [OUT_W-1:0]          restart_val,
  input  logic [OUT_W+FRAC_W-1:0]   step_val,
  input  logic                      ramp_down,
  input  logic                      restart_trig,
  input  logic                      step_trig,
  output logic [OUT_W-1:0]          dac_code
);

  localparam int ACC_W = OUT_W + FRAC_W;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [ACC_W-1:0] acc, acc_nxt;
  logic [ACC_W:0]   sum_up;
  logic             borrow;
  logic [OUT_W-1:0] pipe [LATENCY];

  assign sum_up = {1'b0, acc} + {1'b0, step_val};
  assign borrow = step_val > acc;

  always_comb begin
    acc_nxt = acc;
    if (restart_trig)
      acc_nxt = {restart_val, {FRAC_W{1'b0}}};
    else if (step_trig && !ramp_down)
      acc_nxt = sum_up[ACC_W] ? ACC_MAX : sum_up[ACC_W-1:0];
    else if (step_trig)
      acc_nxt = borrow ? '0 : acc - step_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      for (int i = 0; i < LATENCY; i++) pipe[i] <= '0;
    end else begin
      acc     <= acc_nxt;
      pipe[0] <= acc[ACC_W-1 -: OUT_W];
      for (int i = 1; i < LATENCY; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dac_code = pipe[LATENCY-1];

  assert_restart_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart_trig |=> acc == {$past(restart_val), {FRAC_W{1'b0}}});

  assert_restart_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_trig && step_trig) |=> acc[ACC_W-1 -: OUT_W] == $past(restart_val));

  assert_rise_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_trig && !restart_trig && !ramp_down) |=> acc >= $past(acc));

  assert_fall_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_trig && !restart_trig && ramp_down) |=> acc <= $past(acc));

  assert_top_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_MAX && step_trig && !restart_trig && !ramp_down) |=> acc == ACC_MAX);

  assert_floor_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == '0 && step_trig && !restart_trig && ramp_down) |=> acc == '0);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_trig && !restart_trig) |=> $stable(acc));

endmodule

// File: tb/saw_ramp_gen_test.sv
module saw_ramp_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] restart_val = '0;
  logic [15:0] step_val = '0;
  logic        ramp_down = 1'b0;
  logic        restart_trig = 1'b0;
  logic        step_trig = 1'b0;
  logic [11:0] dac_code;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  saw_ramp_gen uut (
    .clk(clk), .rst_n(rst_n), .restart_val(restart_val), .step_val(step_val),
    .ramp_down(ramp_down), .restart_trig(restart_trig), .step_trig(step_trig),
    .dac_code(dac_code)
  );

  // {restart, step, down, restart_val, step_val, expected code}
  localparam int NV = 19;
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 12'h100, 16'h0000, 12'h100},
    {1'b0, 1'b1, 1'b0, 12'h000, 16'h0008, 12'h100},
    {1'b0, 1'b1, 1'b0, 12'h000, 16'h0008, 12'h101},
    {1'b0, 1'b1, 1'b0, 12'h000, 16'h0150, 12'h116},
    {1'b0, 1'b1, 1'b1, 12'h000, 16'h0020, 12'h114},
    {1'b1, 1'b1, 1'b0, 12'h7A5, 16'h1000, 12'h7A5},
    {1'b0, 1'b1, 1'b1, 12'h000, 16'h7A50, 12'h000},
    {1'b0, 1'b1, 1'b1, 12'h000, 16'h0001, 12'h000},
    {1'b1, 1'b0, 1'b0, 12'hFF0, 16'h0000, 12'hFF0},
    {1'b0, 1'b1, 1'b0, 12'h000, 16'h00F0, 12'hFFF},
    {1'b0, 1'b1, 1'b0, 12'h000, 16'h0020, 12'hFFF},
    {1'b0, 1'b1, 1'b1, 12'h000, 16'h000F, 12'hFFF},
    {1'b0, 1'b1, 1'b1, 12'h000, 16'h0001, 12'hFFE},
    {1'b1, 1'b0, 1'b1, 12'h010, 16'h0000, 12'h010},
    {1'b0, 1'b1, 1'b0, 12'h000, 16'h000F, 12'h010},
    {1'b0, 1'b1, 1'b0, 12'h000, 16'h0001, 12'h011},
    {1'b0, 1'b1, 1'b1, 12'h000, 16'h0005, 12'h010},
    {1'b1, 1'b1, 1'b1, 12'h3C3, 16'hFFFF, 12'h3C3},
    {1'b0, 1'b1, 1'b0, 12'h000, 16'hFFFF, 12'hFFF}
  };

  function automatic string vec_tag(int idx);
    case (idx)
      0, 8, 13:      return "R2";
      5, 17:         return "R3";
      1, 2, 3, 14, 15: return "R4";
      4, 16:         return "R5";
      9, 10, 18:     return "R6";
      6, 7:          return "R7";
      default:       return "R6/R5";
    endcase
  endfunction

  task automatic check(string tag, logic [11:0] got, logic [11:0] want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: dac_code=%03h expected %03h", tag, got, want);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [11:0] prev;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", dac_code, 12'h000);
    rst_n = 1'b1;
    prev = 12'h000;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {restart_trig, step_trig, ramp_down, restart_val, step_val} = VEC[v][42:12];
      @(posedge clk);
      @(negedge clk);
      restart_trig = 1'b0;
      step_trig = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R9 early v%0d", v), dac_code, prev);
      @(posedge clk);
      @(negedge clk);
      check($sformatf("%s R9 v%0d", vec_tag(v), v), dac_code, VEC[v][11:0]);
      prev = VEC[v][11:0];
    end

    // R8: configuration changes without triggers leave the output untouched
    restart_val = 12'h5A5;
    step_val = 16'h1234;
    ramp_down = ~ramp_down;
    repeat (6) @(negedge clk);
    check("R8 hold", dac_code, prev);
    @(negedge clk);
    step_trig = 1'b1;
    ramp_down = 1'b1;
    step_val = 16'h0010;
    @(negedge clk);
    step_trig = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 state kept then R5 step", dac_code, 12'hFFE);

    // R1: reset in mid-run clears the output
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", dac_code, 12'h000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", dac_code, 12'h000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule